// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Servicing

This block is a watchdog timer. It is built around a down counter that reloads from a time-out register. Software keeps it alive by writing a two-word key pair to a key register. A second, different key pair lifts a soft configuration lock. A hard lock, once set, can only be cleared by reset. All configuration goes through a single-cycle register write port with a combinational read port.

The counter advances on one of two external count enables, chosen by a control bit. In window mode, servicing is legal only near the end of the period. An early service is an invalid access and produces either a one-cycle bus-error pulse or a reset request. Time-outs either request a reset at once, or first raise an interrupt and reload, then request a reset if a second time-out follows with no service in between. The reset request is sticky until the block itself is reset.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, TIMEOUT (address 1) reads all ones, WINDOW (address 2) reads 0, IRQ status (address 4) reads 0, COUNT (address 5) reads 0, and irq, rst_req and bus_err are low.
- R2: Changing CTRL bit 0 (enable) from 0 to 1 loads TIMEOUT into the counter. While enabled, the counter drops by one on each selected count enable and COUNT reads 0. While disabled, the counter holds its value and COUNT shows it.
- R3: CTRL bit 3 selects the count enable: 0 selects tick_a and 1 selects tick_b. The unselected enable has no effect on the counter.
- R4: Writing 0xA602 and then 0xB480 to the low 16 bits of KEY (address 3) while enabled reloads the counter from TIMEOUT. Writes of 0xC520 or 0xD928 between the two words are ignored. A repeated 0xA602 keeps the pair armed. Any other value between the two words cancels the pair, and a lone 0xB480 does nothing.
- R5: Writing 0xC520 and then 0xD928 to KEY clears CTRL bit 1 (soft lock), whether or not the watchdog is enabled. Service keys written between the two words are ignored.
- R6: While CTRL bit 1 (soft lock) or CTRL bit 2 (hard lock) is set, writes to CTRL, TIMEOUT and WINDOW are ignored. The hard lock is not cleared by the unlock pair, only by reset.
- R7: With CTRL bit 5 clear, a count enable that finds the counter at 1 or 0 while enabled is a time-out: rst_req rises, so it goes high on the T-th tick after a load of T. It then stays high until reset.
- R8: With CTRL bit 5 set, the first time-out sets the interrupt flag (IRQ bit 0 and the irq output) and reloads the counter. A second time-out with no valid service since the first raises rst_req. A valid service in between makes the next time-out count as a first one again.
- R9: Writing IRQ with bit 0 set clears the interrupt flag. Writing it with bit 0 clear leaves the flag unchanged.
- R10: With CTRL bit 4 (window mode) set, a service is valid only while the counter is below WINDOW. An outside-window service does not reload the counter. It pulses bus_err for one cycle when CTRL bit 6 is clear, and raises rst_req when CTRL bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count enable selected when CTRL bit 3 is 0 |
| tick_b | input | 1 | Count enable selected when CTRL bit 3 is 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Time-out interrupt flag |
| rst_req | output | 1 | Sticky reset request |
| bus_err | output | 1 | One-cycle pulse for an outside-window service |

## Verification
The hardest state to reach is the second time-out in interrupt-then-reset mode, with a valid service placed between the two. Only a service wedged between them shows that the stage bit is cleared, not just the flag. The stimulus lets the first time-out fire, clears the flag through the port, runs the counter down to one, and then services. It then needs two more full periods before rst_req may rise, and the bench checks it stays low after the first. Window edges are reached the same way: the counter is stepped tick by tick to exactly the window value, then to one below it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_TMO  = 3'd1,
    A_WIN  = 3'd2,
    A_KEY  = 3'd3,
    A_IRQ  = 3'd4,
    A_CNT  = 3'd5
  } wd_addr_e;

  localparam int CTRL_W = 7;
  localparam int C_EN  = 0;
  localparam int C_SLK = 1;
  localparam int C_HLK = 2;
  localparam int C_SEL = 3;
  localparam int C_WND = 4;
  localparam int C_ITR = 5;
  localparam int C_RIA = 6;

  localparam logic [15:0] SVC_K1 = 16'hA602;
  localparam logic [15:0] SVC_K2 = 16'hB480;
  localparam logic [15:0] UNL_K1 = 16'hC520;
  localparam logic [15:0] UNL_K2 = 16'hD928;
endpackage

// File: rtl/wdog_keydet.sv
module wdog_keydet #(
  parameter int          KW     = 16,
  parameter logic [KW-1:0] FIRST  = '0,
  parameter logic [KW-1:0] SECOND = '0,
  parameter logic [KW-1:0] ALT_A  = '0,
  parameter logic [KW-1:0] ALT_B  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [KW-1:0] key,
  output logic          hit
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    hit     = 1'b0;
    if (wr) begin
      if (key == FIRST) begin
        armed_d = 1'b1;
      end else if (key == SECOND) begin
        hit     = armed_q;
        armed_d = 1'b0;
      end else if (key != ALT_A && key != ALT_B) begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_KEY_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !armed_q); // R4
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] reload,
  input  logic          itr,
  input  logic          svc,
  output logic [CW-1:0] cnt_q,
  output logic          first_tmo,
  output logic          final_tmo
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_d;
  logic          stage_q, stage_d;

  always_comb begin
    cnt_d     = cnt_q;
    stage_d   = stage_q;
    first_tmo = 1'b0;
    final_tmo = 1'b0;
    if (!run) stage_d = 1'b0;
    if (load) begin
      cnt_d = reload;
      if (svc) stage_d = 1'b0;
    end else if (run && tick) begin
      if (cnt_q <= ONE) begin
        if (itr && !stage_q) begin
          first_tmo = 1'b1;
          stage_d   = 1'b1;
          cnt_d     = reload;
        end else begin
          final_tmo = 1'b1;
          cnt_d     = '0;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q)); // R2
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (final_tmo && itr) |-> stage_q); // R8
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int            CW       = 32,
  parameter int            KW       = 16,
  parameter logic [CW-1:0] TMO_INIT = {CW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_a,
  input  logic          tick_b,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq,
  output logic          rst_req,
  output logic          bus_err
);
  import wdog_pkg::*;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CW-1:0]     tmo_q, tmo_d, win_q, win_d, cnt;
  logic              flag_q, flag_d, rst_q, rst_d, berr_q, berr_d;
  logic              locked, cfg_wr, key_wr, svc_hit, unl_hit;
  logic              en, win_open, svc_ok, svc_bad, en_rise, tick_sel;
  logic              first_tmo, final_tmo;
  logic [KW-1:0]     key;

  assign en       = ctrl_q[C_EN];
  assign locked   = ctrl_q[C_SLK] | ctrl_q[C_HLK];
  assign cfg_wr   = reg_wr && !locked;
  assign key_wr   = reg_wr && (reg_addr == A_KEY);
  assign key      = reg_wdata[KW-1:0];
  assign tick_sel = ctrl_q[C_SEL] ? tick_b : tick_a;
  assign win_open = !ctrl_q[C_WND] || (cnt < win_q);
  assign svc_ok   = svc_hit && en && win_open;
  assign svc_bad  = svc_hit && en && !win_open;

  wdog_keydet #(.KW(KW), .FIRST(SVC_K1), .SECOND(SVC_K2),
                .ALT_A(UNL_K1), .ALT_B(UNL_K2)) u_svc (
    .clk(clk), .rst_n(rst_n), .wr(key_wr), .key(key), .hit(svc_hit));

  wdog_keydet #(.KW(KW), .FIRST(UNL_K1), .SECOND(UNL_K2),
                .ALT_A(SVC_K1), .ALT_B(SVC_K2)) u_unl (
    .clk(clk), .rst_n(rst_n), .wr(key_wr), .key(key), .hit(unl_hit));

  always_comb begin
    ctrl_d = ctrl_q;
    tmo_d  = tmo_q;
    win_d  = win_q;
    if (cfg_wr && reg_addr == A_CTRL) begin
      ctrl_d        = reg_wdata[CTRL_W-1:0];
      ctrl_d[C_HLK] = reg_wdata[C_HLK] | ctrl_q[C_HLK];
    end
    if (cfg_wr && reg_addr == A_TMO) tmo_d = reg_wdata;
    if (cfg_wr && reg_addr == A_WIN) win_d = reg_wdata;
    if (unl_hit) ctrl_d[C_SLK] = 1'b0;
  end

  assign en_rise = ctrl_d[C_EN] & ~ctrl_q[C_EN];

  wdog_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick_sel),
    .load(en_rise | svc_ok), .reload(tmo_q), .itr(ctrl_q[C_ITR]),
    .svc(svc_ok), .cnt_q(cnt), .first_tmo(first_tmo), .final_tmo(final_tmo));

  always_comb begin
    flag_d = flag_q;
    if (reg_wr && reg_addr == A_IRQ && reg_wdata[0]) flag_d = 1'b0;
    if (first_tmo) flag_d = 1'b1;
    rst_d  = rst_q | final_tmo | (svc_bad & ctrl_q[C_RIA]);
    berr_d = svc_bad & ~ctrl_q[C_RIA];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmo_q  <= TMO_INIT;
      win_q  <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tmo_q  <= tmo_d;
      win_q  <= win_d;
      flag_q <= flag_d;
      rst_q  <= rst_d;
      berr_q <= berr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
      A_TMO:   reg_rdata = tmo_q;
      A_WIN:   reg_rdata = win_q;
      A_IRQ:   reg_rdata[0] = flag_q;
      A_CNT:   reg_rdata = en ? '0 : cnt;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = flag_q;
  assign rst_req = rst_q;
  assign bus_err = berr_q;

  AST_HLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_HLK] |=> ctrl_q[C_HLK]); // R6
  AST_LOCK_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(tmo_q) && $stable(win_q))); // R6
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R7
  AST_BERR_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(ctrl_q[C_WND]) && !$past(ctrl_q[C_RIA]))); // R10
  AST_FLAG_NEEDS_ITR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(ctrl_q[C_ITR])); // R8
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  logic        clk, rst_n, tick_a, tick_b, reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, v;
  logic        irq, rst_req, bus_err;
  int          n_run, n_fail;
  bit          done;

  wdog_keyed uut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req), .bus_err(bus_err));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick(input bit use_b, input int n);
    for (int i = 0; i < n; i++) begin
      if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
      @(negedge clk);
      tick_a = 1'b0; tick_b = 1'b0;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic service;
    wr(3, 32'hA602); wr(3, 32'hB480);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    tick_a = 0; tick_b = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    @(negedge clk);
    do_reset;

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 timeout", v, 32'hFFFF_FFFF);
    rd(2, v); chk("R1 window", v, 0);
    rd(4, v); chk("R1 irq reg", v, 0);
    rd(5, v); chk("R1 count", v, 0);
    chk("R1 outputs", {irq, rst_req, bus_err}, 0);

    // R2 sweep of tick counts
    wr(1, 6);
    for (int k = 0; k < 6; k++) begin
      wr(0, 1);
      rd(5, v); chk("R2 count reads zero enabled", v, 0);
      tick(0, k);
      wr(0, 0);
      rd(5, v); chk("R2 frozen count", v, 6 - k);
      tick(0, 2);
      rd(5, v); chk("R2 hold while disabled", v, 6 - k);
    end

    // R3 clock select
    wr(0, 1); tick(1, 3); tick(0, 2); wr(0, 0);
    rd(5, v); chk("R3 sel a ignores b", v, 4);
    wr(0, 9); tick(0, 3); tick(1, 1); wr(0, 8);
    rd(5, v); chk("R3 sel b ignores a", v, 5);

    // R4 service sequences
    wr(0, 1); tick(0, 3); wr(3, 32'hA602); wr(3, 32'hC520); wr(3, 32'hB480);
    tick(0, 1); wr(0, 0);
    rd(5, v); chk("R4 service with unlock key between", v, 5);
    wr(0, 1); tick(0, 3); wr(3, 32'hA602); wr(3, 32'hA602); wr(3, 32'hB480);
    wr(0, 0); rd(5, v); chk("R4 repeated first key", v, 6);
    wr(0, 1); tick(0, 2); wr(3, 32'hA602); wr(3, 32'h1234); wr(3, 32'hB480);
    wr(0, 0); rd(5, v); chk("R4 junk cancels", v, 4);
    wr(0, 1); tick(0, 2); wr(3, 32'hB480);
    wr(0, 0); rd(5, v); chk("R4 lone second key", v, 4);

    // R5 / R6 soft lock
    wr(0, 2); wr(1, 9);
    rd(1, v); chk("R6 soft lock blocks timeout", v, 6);
    wr(2, 5); rd(2, v); chk("R6 soft lock blocks window", v, 0);
    wr(0, 0); rd(0, v); chk("R6 soft lock blocks ctrl", v, 2);
    wr(3, 32'hC520); wr(3, 32'hA602); wr(3, 32'hD928);
    rd(0, v); chk("R5 unlock while disabled", v, 0);
    wr(1, 9); rd(1, v); chk("R5 writable after unlock", v, 9);
    // R6 hard lock
    wr(0, 4); wr(1, 3); rd(1, v); chk("R6 hard lock blocks timeout", v, 9);
    wr(3, 32'hC520); wr(3, 32'hD928); wr(0, 0);
    rd(0, v); chk("R6 hard lock survives unlock", v, 4);
    do_reset;
    rd(0, v); chk("R6 reset clears hard lock", v, 0);

    // R7 immediate reset
    wr(1, 4); wr(0, 1); tick(0, 3);
    chk("R7 no reset before T ticks", rst_req, 0);
    tick(0, 1);
    chk("R7 reset at T-th tick", rst_req, 1);
    repeat (5) @(negedge clk);
    chk("R7 reset sticky", rst_req, 1);
    do_reset;

    // R8 / R9 interrupt then reset
    wr(1, 4); wr(0, 33); tick(0, 4);
    chk("R8 first timeout irq", irq, 1);
    chk("R8 first timeout no reset", rst_req, 0);
    rd(4, v); chk("R8 flag register", v, 1);
    wr(4, 0); rd(4, v); chk("R9 write zero keeps flag", v, 1);
    wr(4, 1); rd(4, v); chk("R9 write one clears flag", v, 0);
    chk("R9 irq low", irq, 0);
    tick(0, 3); service; tick(0, 4);
    chk("R8 service between resets stage", rst_req, 0);
    chk("R8 irq again", irq, 1);
    tick(0, 3);
    chk("R8 no reset before second period ends", rst_req, 0);
    tick(0, 1);
    chk("R8 second timeout reset", rst_req, 1);
    do_reset;

    // R10 window mode
    wr(1, 8); wr(2, 3); wr(0, 17);
    service;
    chk("R10 early service bus error", bus_err, 1);
    chk("R10 early service no reset", rst_req, 0);
    @(negedge clk);
    chk("R10 bus error one cycle", bus_err, 0);
    tick(0, 1); wr(0, 16); rd(5, v); chk("R10 early service no reload", v, 7);
    wr(0, 17); tick(0, 5); service;
    chk("R10 counter equal window rejected", bus_err, 1);
    tick(0, 1); service;
    chk("R10 inside window no error", bus_err, 0);
    tick(0, 1); wr(0, 16); rd(5, v); chk("R10 inside window reload", v, 7);
    wr(0, 0); wr(0, 81); service;
    chk("R10 early service reset select", rst_req, 1);
    chk("R10 no bus error when reset selected", bus_err, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule